// File: doc/BRIEF.md
# PMP Configuration and Address Register Bank

This block stores the physical-memory-protection settings of a hart: one 8-bit configuration byte and one address register per entry. Software reaches them through a plain CSR port made of an address, write data, a write strobe and combinational read data. Configuration bytes are packed eight to a 64-bit register, so only even configuration indices exist. Every address register has an index of its own.

On each write the bank applies the lock rules. A locked entry freezes its own byte and its own address. A locked entry in top-of-range mode also freezes the address register of the entry just below it. The stored values are driven out as flat per-entry vectors for the permission checker. Every write that changes at least one stored register raises a one-cycle flush pulse, so that cached permissions get dropped.

Top module: `pmp_csr_bank`

## Requirements
- R1: After reset, all configuration bytes and all address registers read zero, and the flush output is low.
- R2: The configuration register at CSR `CFG_BASE + r` (r even) holds entries 4r to 4r+7, with entry 4r+k in bits 8k+7:8k. It reads back as those bytes concatenated, and a set top bit in one byte is never copied into higher bytes.
- R3: A configuration index that is odd, or that lies at or beyond `NUM_ENTRIES/4`, reads zero. A write to it changes no state and raises no flush.
- R4: The address register of entry i is at CSR `ADDR_BASE + i` and keeps the low `ADDR_BITS` bits of the write data; the upper bits read zero. An index from `NUM_ENTRIES` to 63 reads zero, and writes to it are ignored.
- R5: Configuration byte layout: bits 2:0 are the R, W and X permissions, bits 4:3 are the mode (0 off, 1 top-of-range, 2 four-byte, 3 naturally aligned power of two), and bit 7 is the lock. On a configuration write, every unlocked byte of the register takes its new value in the same cycle, and a locked byte keeps its old value.
- R6: When entry i is locked, writes to the address register of entry i are ignored.
- R7: When entry i is locked and in top-of-range mode, writes to the address register of entry i-1 are ignored. A locked entry in any other mode, or an unlocked top-of-range entry, does not block the address register below it.
- R8: A lock on entry i does not block writes to the configuration byte of entry i-1.
- R9: A set lock bit cannot be cleared by any write; only reset clears it.
- R10: A write that changes at least one register drives the flush output high for exactly the one cycle after the write edge. A write that is fully blocked or ignored leaves the flush output low.
- R11: `entryCfg` and `entryAddr` show the stored byte and address of entry i at slices `[8i +: 8]` and `[ADDR_BITS*i +: ADDR_BITS]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csrAddr | input | 12 | CSR address |
| csrWdata | input | 64 | Write data |
| csrWe | input | 1 | Write strobe |
| csrRdata | output | 64 | Read data for `csrAddr` (combinational) |
| flushPulse | output | 1 | One-cycle pulse after a write that changed state |
| entryCfg | output | 8*NUM_ENTRIES | Configuration byte of each entry |
| entryAddr | output | ADDR_BITS*NUM_ENTRIES | Address register of each entry |

## Verification
The bench builds the bank with 16 entries and 54-bit address registers. With these values two configuration registers exist (indices 0 and 2), so index 4 and the odd indices act as unimplemented probes. Address indices 16 to 63 fall outside storage. Writing all ones exposes the truncation of the upper ten address bits. Lock cases place a locked top-of-range entry, a locked power-of-two entry and an unlocked top-of-range entry beside writable neighbours, so that each blocking rule is seen both holding and not holding.

// File: rtl/pmp_bank_pkg.sv
package pmp_bank_pkg;
  localparam int XLEN_W = 64;
  localparam int SEL_W = 6;
  localparam int LOCK_POS = 7;
  localparam int MODE_LO = 3;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_TOR   = 2'd1,
    MODE_NA4   = 2'd2,
    MODE_NAPOT = 2'd3
  } pmpMode_e;

  typedef struct packed {
    logic             cfgWr;
    logic [SEL_W-1:0] cfgReg;
    logic [7:0]       byteMask;
    logic             addrWr;
    logic [SEL_W-1:0] addrIdx;
    logic             rdCfg;
    logic             rdAddr;
    logic [SEL_W-1:0] rdSel;
  } bankStrobe_t;
endpackage

// File: rtl/pmpBankCtrl.sv
module pmpBankCtrl
  import pmp_bank_pkg::*;
#(
  parameter int          NUM_ENTRIES = 16,
  parameter logic [11:0] CFG_BASE    = 12'h3A0,
  parameter logic [11:0] ADDR_BASE   = 12'h3B0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [11:0]            csrAddr,
  input  logic                   csrWe,
  input  logic [NUM_ENTRIES-1:0] lockVec,
  input  logic [NUM_ENTRIES-1:0] torVec,
  output bankStrobe_t            strobe,
  output logic                   flushPulse
);
  localparam int NUM_CFG_REGS = NUM_ENTRIES / 8;
  localparam logic [11:0] CFG_END  = CFG_BASE + 12'd16;
  localparam logic [11:0] ADDR_END = ADDR_BASE + 12'd64;

  logic [11:0] cfgOff, addrOff;
  logic        inCfgWin, inAddrWin;
  logic [3:0]  cfgIdx;
  logic [SEL_W-1:0] cfgRegSel, addrSel;
  logic        cfgValid, addrValid;
  logic [7:0]  byteMask;
  logic [NUM_ENTRIES-1:0] protectVec;
  logic        addrBlocked;
  logic        flushQ;

  assign cfgOff    = csrAddr - CFG_BASE;
  assign addrOff   = csrAddr - ADDR_BASE;
  assign inCfgWin  = (csrAddr >= CFG_BASE) && (csrAddr < CFG_END);
  assign inAddrWin = (csrAddr >= ADDR_BASE) && (csrAddr < ADDR_END);
  assign cfgIdx    = cfgOff[3:0];
  assign cfgRegSel = SEL_W'(cfgIdx[3:1]);
  assign addrSel   = addrOff[SEL_W-1:0];
  assign cfgValid  = inCfgWin && !cfgIdx[0] && (int'(cfgIdx[3:1]) < NUM_CFG_REGS);
  assign addrValid = inAddrWin && (int'(addrSel) < NUM_ENTRIES);

  // Per-entry address guard: own lock, or locked TOR neighbour above.
  genvar gi;
  generate
    for (gi = 0; gi < NUM_ENTRIES; gi++) begin : g_protect
      if (gi + 1 < NUM_ENTRIES) begin : g_mid
        assign protectVec[gi] = lockVec[gi] | (lockVec[gi+1] & torVec[gi+1]);
      end else begin : g_top
        assign protectVec[gi] = lockVec[gi];
      end
    end
  endgenerate

  always_comb begin
    byteMask = '0;
    for (int k = 0; k < 8; k++) begin
      for (int e = 0; e < NUM_ENTRIES; e++) begin
        if ((e / 8 == int'(cfgRegSel)) && (e % 8 == k)) byteMask[k] = !lockVec[e];
      end
    end
  end

  always_comb begin
    addrBlocked = 1'b1;
    for (int e = 0; e < NUM_ENTRIES; e++) begin
      if (int'(addrSel) == e) addrBlocked = protectVec[e];
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.cfgReg   = cfgRegSel;
    strobe.byteMask = byteMask;
    strobe.addrIdx  = addrSel;
    strobe.cfgWr    = csrWe && cfgValid && (|byteMask);
    strobe.addrWr   = csrWe && addrValid && !addrBlocked;
    strobe.rdCfg    = cfgValid;
    strobe.rdAddr   = addrValid;
    strobe.rdSel    = cfgValid ? cfgRegSel : addrSel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flushQ <= 1'b0;
    else        flushQ <= strobe.cfgWr | strobe.addrWr;
  end
  assign flushPulse = flushQ;

  AST_FLUSH_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    flushQ |-> $past(csrWe)); // R10
  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobe.cfgWr && strobe.addrWr)); // R3
  AST_ODD_CFG_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (inCfgWin && cfgIdx[0]) |-> !strobe.cfgWr); // R3
endmodule

// File: rtl/pmpBankDatapath.sv
module pmpBankDatapath
  import pmp_bank_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int ADDR_BITS   = 54
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  bankStrobe_t                      strobe,
  input  logic [XLEN_W-1:0]                wdata,
  output logic [XLEN_W-1:0]                rdata,
  output logic [NUM_ENTRIES-1:0]           lockVec,
  output logic [NUM_ENTRIES-1:0]           torVec,
  output logic [8*NUM_ENTRIES-1:0]         entryCfg,
  output logic [ADDR_BITS*NUM_ENTRIES-1:0] entryAddr
);
  logic [7:0]           cfgQ  [NUM_ENTRIES];
  logic [ADDR_BITS-1:0] addrQ [NUM_ENTRIES];

  genvar gi;
  generate
    for (gi = 0; gi < NUM_ENTRIES; gi++) begin : g_entry
      localparam logic [SEL_W-1:0] MY_REG = SEL_W'(gi / 8);
      localparam logic [SEL_W-1:0] MY_IDX = SEL_W'(gi);
      localparam int BYTE_K = gi % 8;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfgQ[gi] <= '0;
        else if (strobe.cfgWr && strobe.cfgReg == MY_REG && strobe.byteMask[BYTE_K])
          cfgQ[gi] <= wdata[BYTE_K*8 +: 8];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) addrQ[gi] <= '0;
        else if (strobe.addrWr && strobe.addrIdx == MY_IDX)
          addrQ[gi] <= wdata[ADDR_BITS-1:0];
      end

      assign lockVec[gi] = cfgQ[gi][LOCK_POS];
      assign torVec[gi]  = (pmpMode_e'(cfgQ[gi][MODE_LO +: 2]) == MODE_TOR);
      assign entryCfg[gi*8 +: 8] = cfgQ[gi];
      assign entryAddr[gi*ADDR_BITS +: ADDR_BITS] = addrQ[gi];

      AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        cfgQ[gi][LOCK_POS] |=> cfgQ[gi][LOCK_POS]); // R9
      AST_LOCKED_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        cfgQ[gi][LOCK_POS] |=> $stable(cfgQ[gi])); // R5
      AST_LOCKED_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        cfgQ[gi][LOCK_POS] |=> $stable(addrQ[gi])); // R6
      if (gi + 1 < NUM_ENTRIES) begin : g_tor
        AST_TOR_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
          (cfgQ[gi+1][LOCK_POS] && cfgQ[gi+1][MODE_LO +: 2] == 2'd1)
          |=> $stable(addrQ[gi])); // R7
      end
    end
  endgenerate

  always_comb begin
    rdata = '0;
    if (strobe.rdCfg) begin
      for (int e = 0; e < NUM_ENTRIES; e++) begin
        if (e / 8 == int'(strobe.rdSel)) rdata[(e % 8)*8 +: 8] = cfgQ[e];
      end
    end else if (strobe.rdAddr) begin
      for (int e = 0; e < NUM_ENTRIES; e++) begin
        if (e == int'(strobe.rdSel)) rdata[ADDR_BITS-1:0] = addrQ[e];
      end
    end
  end
endmodule

// File: rtl/pmp_csr_bank.sv
module pmp_csr_bank
  import pmp_bank_pkg::*;
#(
  parameter int          NUM_ENTRIES = 16,
  parameter int          ADDR_BITS   = 54,
  parameter logic [11:0] CFG_BASE    = 12'h3A0,
  parameter logic [11:0] ADDR_BASE   = 12'h3B0
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [11:0]                      csrAddr,
  input  logic [63:0]                      csrWdata,
  input  logic                             csrWe,
  output logic [63:0]                      csrRdata,
  output logic                             flushPulse,
  output logic [8*NUM_ENTRIES-1:0]         entryCfg,
  output logic [ADDR_BITS*NUM_ENTRIES-1:0] entryAddr
);
  localparam logic [11:0] ADDR_LIMIT = ADDR_BASE + 12'(NUM_ENTRIES);
  localparam logic [11:0] ADDR_END   = ADDR_BASE + 12'd64;

  bankStrobe_t            strobe;
  logic [NUM_ENTRIES-1:0] lockVec;
  logic [NUM_ENTRIES-1:0] torVec;

  pmpBankCtrl #(
    .NUM_ENTRIES(NUM_ENTRIES), .CFG_BASE(CFG_BASE), .ADDR_BASE(ADDR_BASE)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .csrAddr(csrAddr), .csrWe(csrWe),
    .lockVec(lockVec), .torVec(torVec), .strobe(strobe), .flushPulse(flushPulse)
  );

  pmpBankDatapath #(
    .NUM_ENTRIES(NUM_ENTRIES), .ADDR_BITS(ADDR_BITS)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .wdata(csrWdata),
    .rdata(csrRdata), .lockVec(lockVec), .torVec(torVec),
    .entryCfg(entryCfg), .entryAddr(entryAddr)
  );

  AST_ADDR_OOR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (csrAddr >= ADDR_LIMIT && csrAddr < ADDR_END) |-> csrRdata == '0); // R4
  AST_RESET_NO_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !flushPulse); // R1
endmodule

// File: tb/pmp_csr_bank_tb.sv
module pmp_csr_bank_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NE = 16;
  localparam int AB = 54;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [11:0] csrAddr = '0;
  logic [63:0] csrWdata = '0;
  logic csrWe = 1'b0;
  logic [63:0] csrRdata;
  logic flushPulse;
  logic [8*NE-1:0] entryCfg;
  logic [AB*NE-1:0] entryAddr;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pmp_csr_bank u_dut (
    .clk(clk), .rst_n(rst_n), .csrAddr(csrAddr), .csrWdata(csrWdata),
    .csrWe(csrWe), .csrRdata(csrRdata), .flushPulse(flushPulse),
    .entryCfg(entryCfg), .entryAddr(entryAddr)
  );

  typedef struct packed {
    logic        isRead;
    logic [11:0] addr;
    logic [63:0] data;
    logic [63:0] expv;
  } vec_t;

  // Writes expect the flush level; reads expect the read data.
  localparam vec_t VECS [12] = '{
    '{1'b0, 12'h3A0, 64'h1122_3344_5566_7700, 64'd1},               // R2
    '{1'b1, 12'h3A0, 64'd0, 64'h1122_3344_5566_7700},               // R2
    '{1'b0, 12'h3A2, 64'h0102_0304_0506_0708, 64'd1},               // R2
    '{1'b1, 12'h3A2, 64'd0, 64'h0102_0304_0506_0708},               // R2
    '{1'b0, 12'h3A1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0},               // R3
    '{1'b1, 12'h3A1, 64'd0, 64'd0},                                 // R3
    '{1'b0, 12'h3A4, 64'h0F0F_0F0F_0F0F_0F0F, 64'd0},               // R3
    '{1'b1, 12'h3A0, 64'd0, 64'h1122_3344_5566_7700},               // R3
    '{1'b0, 12'h3B5, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1},               // R4
    '{1'b1, 12'h3B5, 64'd0, 64'h003F_FFFF_FFFF_FFFF},               // R4
    '{1'b0, 12'h3C5, 64'h0000_0000_0000_1234, 64'd0},               // R4
    '{1'b1, 12'h3C5, 64'd0, 64'd0}                                  // R4
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic doWrite(input logic [11:0] a, input logic [63:0] d, output logic f);
    @(negedge clk);
    csrAddr = a; csrWdata = d; csrWe = 1'b1;
    @(negedge clk);
    csrWe = 1'b0;
    f = flushPulse;
  endtask

  task automatic doRead(input logic [11:0] a, output logic [63:0] v);
    @(negedge clk);
    csrAddr = a; csrWe = 1'b0;
    #1 v = csrRdata;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic f;
    logic [63:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    doRead(12'h3A0, v); check("R1 cfg0", v, 64'd0);
    doRead(12'h3B3, v); check("R1 addr3", v, 64'd0);
    check("R1 flush", {63'd0, flushPulse}, 64'd0);

    for (int i = 0; i < 12; i++) begin
      if (VECS[i].isRead) begin
        doRead(VECS[i].addr, v);
        check($sformatf("vector %0d read", i), v, VECS[i].expv);
      end else begin
        doWrite(VECS[i].addr, VECS[i].data, f);
        check($sformatf("vector %0d flush", i), {63'd0, f}, VECS[i].expv);
      end
    end
    check("R11 cfg entry8", {56'd0, entryCfg[8*8 +: 8]}, 64'h08);
    check("R11 addr entry5", {10'd0, entryAddr[5*AB +: AB]}, 64'h003F_FFFF_FFFF_FFFF);

    doReset();
    // entry1 locked TOR (0x88)
    doWrite(12'h3A0, 64'h0000_0000_0000_8800, f);
    check("R10 cfg write flush", {63'd0, f}, 64'd1);
    @(negedge clk);
    check("R10 single cycle", {63'd0, flushPulse}, 64'd0);
    doWrite(12'h3B0, 64'hAAAA, f);
    check("R10 blocked no flush", {63'd0, f}, 64'd0);
    doRead(12'h3B0, v); check("R7 TOR guards addr0", v, 64'd0);
    doWrite(12'h3B1, 64'h55, f);
    doRead(12'h3B1, v); check("R6 own addr locked", v, 64'd0);
    doWrite(12'h3A0, 64'h0000_0000_0000_0007, f);
    doRead(12'h3A0, v); check("R8 byte below lock writable", v, 64'h0000_0000_0000_8807);
    // entry5 locked NAPOT, entry7 unlocked TOR
    doWrite(12'h3A0, 64'h0800_9800_0000_8807, f);
    doRead(12'h3A0, v); check("R5 mixed bytes", v, 64'h0800_9800_0000_8807);
    doWrite(12'h3B4, 64'h1234, f);
    doRead(12'h3B4, v); check("R7 NAPOT lock no guard", v, 64'h1234);
    doWrite(12'h3B6, 64'h77, f);
    doRead(12'h3B6, v); check("R7 unlocked TOR no guard", v, 64'h77);
    doWrite(12'h3B5, 64'h99, f);
    doRead(12'h3B5, v); check("R6 entry5 addr locked", v, 64'd0);
    doWrite(12'h3A0, 64'd0, f);
    doRead(12'h3A0, v); check("R9 lock sticky", v, 64'h0000_9800_0000_8800);
    check("R11 cfg entry1", {56'd0, entryCfg[15:8]}, 64'h88);

    doReset();
    doRead(12'h3A0, v); check("R9 reset clears lock", v, 64'd0);
    doRead(12'h3B4, v); check("R1 addr4 after reset", v, 64'd0);
    doWrite(12'h3A0, 64'h0000_0000_8000_0000, f);
    doRead(12'h3A0, v); check("R2 no sign extension", v, 64'h0000_0000_8000_0000);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule